// File: doc/BRIEF.md
# Trailing-Load Block Retention Tracker

This block sits beside the data cache of a core that runs two redundant copies of one program, a leading copy and a trailing copy. It makes sure that both copies read the same value from any cache block. The leading copy loads a block first. The tracker then keeps a per-block count of trailing loads to that block that have not yet retired. While that count is above zero, the cache may neither evict nor invalidate the block, so the trailing copy later finds the same contents.

A leading load to an address the tracker does not hold claims a free entry and sets its count to one. A leading load to an address it already holds raises that count. Each trailing retirement lowers the count, and an entry whose count reaches zero is released. The cache asks about a block before it replaces or invalidates it, and gets an answer in the same cycle. The answer is deny if the block is tracked, and grant otherwise. A denial also marks the entry as owing an invalidation. When such a marked entry is released, the tracker emits a one-cycle deferred-invalidate pulse carrying the block address, so the cache can finish the work it was refused. When the leading load can neither find its block nor claim a free entry, it is told to stall.

Top module: `lead_load_tracker`

## Requirements
- R1: After reset no block is tracked. Every replacement query is granted, `lead_stall` is low and `defer_vld` is low.
- R2: An accepted leading load to an untracked address claims an entry with count one. From the next cycle, a query for that address is denied.
- R3: Each accepted leading load to a tracked address raises its count by one, and each trailing retirement to it lowers the count by one. Queries stay denied until the count has returned to zero.
- R4: The query answer is combinational in the cycle of `evict_req`. `evict_deny` is high exactly when the queried address is tracked, and `evict_grant` is high exactly when it is not. Both are low when `evict_req` is low.
- R5: If a query on an entry was denied, then the cycle after the retirement that brings that entry's count to zero has `defer_vld` high and `defer_addr` equal to the block address. An entry that was never denied releases without a pulse.
- R6: When all DEPTH entries are in use, a leading load to an untracked address sees `lead_stall` high in the same cycle and claims nothing. A leading load to a tracked address is still accepted.
- R7: A leading load to an entry whose count equals 2^CNT_W-1 sees `lead_stall` high, and the count does not change.
- R8: A trailing retirement to an untracked address has no effect.
- R9: An accepted leading load and a trailing retirement to the same tracked address in one cycle leave its count unchanged.
- R10: A released entry can be claimed again, so a leading load that stalled on a full tracker is accepted after one entry is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_vld | input | 1 | Leading-copy load presented |
| lead_addr | input | ADDR_W | Block address of the leading load |
| lead_stall | output | 1 | Leading load not accepted this cycle |
| trail_vld | input | 1 | Trailing-copy load retired |
| trail_addr | input | ADDR_W | Block address of the retired trailing load |
| evict_req | input | 1 | Cache asks to replace or invalidate a block |
| evict_addr | input | ADDR_W | Block address the cache wants to drop |
| evict_deny | output | 1 | Request refused; block still in use |
| evict_grant | output | 1 | Request allowed |
| defer_vld | output | 1 | Deferred invalidation now allowed |
| defer_addr | output | ADDR_W | Block address for the deferred invalidation |

## Verification
`lead_stall`, `evict_deny` and `evict_grant` are due in the same cycle as their stimulus. The bench therefore drives inputs on the falling edge and compares these outputs one nanosecond later, before the next rising edge. A count change or a new entry becomes visible to queries from the cycle after the edge that takes the load or retirement. `defer_vld` and `defer_addr` are registered, so they appear one cycle after the releasing retirement. The behavioural model records that pulse at the edge and checks it in the following step, and a final idle step makes sure the last pulse is compared.

// File: rtl/lt_pkg.sv
package lt_pkg;
  // Default geometry of the tracker
  localparam int unsigned LT_DEPTH  = 16;
  localparam int unsigned LT_ADDR_W = 26;
  localparam int unsigned LT_CNT_W  = 4;
endpackage

// File: rtl/lt_cam.sv
// Compares one query address against every live entry
module lt_cam #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 26
) (
  input  logic [DEPTH-1:0]             live,
  input  logic [DEPTH-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]            query,
  output logic [DEPTH-1:0]             hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = live[i] && (tags[i] == query);
  end
endmodule

// File: rtl/lt_free_pick.sv
// Lowest-index free entry, one-hot
module lt_free_pick #(
  parameter int unsigned DEPTH = 16
) (
  input  logic [DEPTH-1:0] live,
  output logic [DEPTH-1:0] pick,
  output logic             any_free
);
  logic [DEPTH:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < DEPTH; i++) begin : g_pick
    assign pick[i]    = !live[i] && !taken[i];
    assign taken[i+1] = taken[i] || !live[i];
  end
  assign any_free = taken[DEPTH];
endmodule

// File: rtl/lt_entry.sv
// One tracked block: address, outstanding trailing count, owed-invalidate mark
module lt_entry #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic [ADDR_W-1:0] claim_addr,
  input  logic              bump,
  input  logic              drop,
  input  logic              mark,
  output logic              live,
  output logic [ADDR_W-1:0] tag,
  output logic              at_max,
  output logic              owed_now
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic              live_q, live_d;
  logic [ADDR_W-1:0] tag_q, tag_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              owe_q, owe_d;
  logic              en;

  always_comb begin
    live_d   = live_q;
    tag_d    = tag_q;
    cnt_d    = cnt_q;
    owe_d    = owe_q;
    owed_now = 1'b0;
    en       = 1'b0;
    if (claim) begin
      en     = 1'b1;
      live_d = 1'b1;
      tag_d  = claim_addr;
      cnt_d  = CNT_ONE;
      owe_d  = 1'b0;
    end else if (live_q && (bump || drop || mark)) begin
      en    = 1'b1;
      cnt_d = cnt_q + CNT_W'(bump) - CNT_W'(drop);
      owe_d = owe_q || mark;
      if (cnt_d == '0) begin
        owed_now = owe_d;
        live_d   = 1'b0;
        owe_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      tag_q  <= '0;
      cnt_q  <= '0;
      owe_q  <= 1'b0;
    end else if (en) begin
      live_q <= live_d;
      tag_q  <= tag_d;
      cnt_q  <= cnt_d;
      owe_q  <= owe_d;
    end
  end

  assign live   = live_q;
  assign tag    = tag_q;
  assign at_max = live_q && (cnt_q == CNT_TOP);

  // R3: a live entry never holds a zero count
  p_live_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (cnt_q != '0));
  // R7: a saturated count is never raised
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && cnt_q == CNT_TOP && !claim) |=> (cnt_q != '0 || !live_q));
endmodule

// File: rtl/lead_load_tracker.sv
module lead_load_tracker #(
  parameter int unsigned DEPTH  = lt_pkg::LT_DEPTH,
  parameter int unsigned ADDR_W = lt_pkg::LT_ADDR_W,
  parameter int unsigned CNT_W  = lt_pkg::LT_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_vld,
  input  logic [ADDR_W-1:0] lead_addr,
  output logic              lead_stall,
  input  logic              trail_vld,
  input  logic [ADDR_W-1:0] trail_addr,
  input  logic              evict_req,
  input  logic [ADDR_W-1:0] evict_addr,
  output logic              evict_deny,
  output logic              evict_grant,
  output logic              defer_vld,
  output logic [ADDR_W-1:0] defer_addr
);
  logic [DEPTH-1:0]             live, at_max, owed;
  logic [DEPTH-1:0][ADDR_W-1:0] tags;
  logic [DEPTH-1:0]             lead_hit, trail_hit, evict_hit;
  logic [DEPTH-1:0]             free_pick, claim_v, bump_v, drop_v, mark_v;
  logic                         any_free, lead_any, lead_ok;
  logic                         dv_d;
  logic [ADDR_W-1:0]            da_d;

  lt_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_cam_lead (
    .live(live), .tags(tags), .query(lead_addr), .hit(lead_hit));
  lt_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_cam_trail (
    .live(live), .tags(tags), .query(trail_addr), .hit(trail_hit));
  lt_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_cam_evict (
    .live(live), .tags(tags), .query(evict_addr), .hit(evict_hit));
  lt_free_pick #(.DEPTH(DEPTH)) i_pick (
    .live(live), .pick(free_pick), .any_free(any_free));

  assign lead_any   = |lead_hit;
  assign lead_stall = lead_vld && (lead_any ? |(lead_hit & at_max) : !any_free);
  assign lead_ok    = lead_vld && !lead_stall;
  assign claim_v    = free_pick & {DEPTH{lead_ok && !lead_any}};
  assign bump_v     = lead_hit  & {DEPTH{lead_ok}};
  assign drop_v     = trail_hit & {DEPTH{trail_vld}};
  assign mark_v     = evict_hit & {DEPTH{evict_req}};

  assign evict_deny  = evict_req && (|evict_hit);
  assign evict_grant = evict_req && !(|evict_hit);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    lt_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ent (
      .clk(clk), .rst_n(rst_n),
      .claim(claim_v[i]), .claim_addr(lead_addr),
      .bump(bump_v[i]), .drop(drop_v[i]), .mark(mark_v[i]),
      .live(live[i]), .tag(tags[i]), .at_max(at_max[i]),
      .owed_now(owed[i]));
  end

  always_comb begin
    dv_d = |owed;
    da_d = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (owed[i]) da_d = da_d | tags[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_vld  <= 1'b0;
      defer_addr <= '0;
    end else begin
      defer_vld  <= dv_d;
      defer_addr <= da_d;
    end
  end

  // R4: deny and grant never together, and silent without a request
  p_resp_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(evict_deny && evict_grant));
  p_resp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_req |-> (!evict_deny && !evict_grant));
  // R2: at most one entry claimed per cycle
  p_claim_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_v));
  // R5: a deferred invalidation only follows a trailing retirement
  p_defer_after_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trail_vld ##0 1'b1 or 1'b1 |=> (!defer_vld || $past(trail_vld)));
  // R8: a trailing retirement matches at most one entry
  p_trail_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trail_hit));
endmodule

// File: tb/test_lead_load_tracker.sv
`timescale 1ns/1ps
module test_lead_load_tracker;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int CW    = 3;
  localparam int MAXC  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic lead_vld, trail_vld, evict_req;
  logic [AW-1:0] lead_addr, trail_addr, evict_addr;
  logic lead_stall, evict_deny, evict_grant, defer_vld;
  logic [AW-1:0] defer_addr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int cnt[int];
  bit owe[int];
  bit exp_dv = 0;
  int exp_da = 0;

  always #2 clk = ~clk;

  lead_load_tracker #(.DEPTH(DEPTH), .ADDR_W(AW), .CNT_W(CW)) i_lead_load_tracker (
    .clk(clk), .rst_n(rst_n),
    .lead_vld(lead_vld), .lead_addr(lead_addr), .lead_stall(lead_stall),
    .trail_vld(trail_vld), .trail_addr(trail_addr),
    .evict_req(evict_req), .evict_addr(evict_addr),
    .evict_deny(evict_deny), .evict_grant(evict_grant),
    .defer_vld(defer_vld), .defer_addr(defer_addr));

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit lv, int la, bit tv, int ta, bit ev, int ea);
    bit e_stall, e_deny, e_grant, l_hit, t_hit;
    @(negedge clk);
    lead_vld = lv;  lead_addr  = AW'(la);
    trail_vld = tv; trail_addr = AW'(ta);
    evict_req = ev; evict_addr = AW'(ea);
    #1;
    l_hit   = cnt.exists(la);
    t_hit   = cnt.exists(ta);
    e_stall = lv && (l_hit ? (cnt[la] == MAXC) : (cnt.num() == DEPTH));
    e_deny  = ev && cnt.exists(ea);
    e_grant = ev && !cnt.exists(ea);
    chk(tag, "lead_stall", int'(lead_stall), int'(e_stall));
    chk(tag, "evict_deny", int'(evict_deny), int'(e_deny));
    chk(tag, "evict_grant", int'(evict_grant), int'(e_grant));
    chk(tag, "defer_vld", int'(defer_vld), int'(exp_dv));
    if (exp_dv) chk(tag, "defer_addr", int'(defer_addr), exp_da);
    @(posedge clk);
    // reference update from pre-edge state
    exp_dv = 0;
    if (e_deny) owe[ea] = 1;
    if (lv && !e_stall) begin
      if (l_hit) cnt[la] = cnt[la] + 1;
      else begin cnt[la] = 1; owe[la] = 0; end
    end
    if (tv && t_hit) begin
      cnt[ta] = cnt[ta] - 1;
      if (cnt[ta] == 0) begin
        exp_dv = owe[ta];
        exp_da = ta;
        cnt.delete(ta);
        owe.delete(ta);
      end
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    lead_vld = 0; trail_vld = 0; evict_req = 0;
    lead_addr = '0; trail_addr = '0; evict_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    step("R1", 0, 0, 0, 0, 1, 8'h10);
    // R2 claim then deny
    step("R2", 1, 8'h10, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 1, 8'h10);
    // R4 untracked query granted, no request silent
    step("R4", 0, 0, 0, 0, 1, 8'h22);
    idle("R4");
    // R3 counting, with deny above marking the entry
    step("R3", 1, 8'h10, 0, 0, 0, 0);
    step("R3", 1, 8'h10, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 8'h10, 1, 8'h10);
    step("R3", 0, 0, 1, 8'h10, 1, 8'h10);
    step("R5", 0, 0, 1, 8'h10, 1, 8'h10);
    step("R5", 0, 0, 0, 0, 1, 8'h10);
    // R5 never denied: no pulse on release
    step("R5", 1, 8'h44, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 8'h44, 0, 0);
    idle("R5");
    // R8 retirement to untracked address ignored
    step("R8", 1, 8'h60, 0, 0, 0, 0);
    step("R8", 0, 0, 1, 8'h61, 1, 8'h60);
    step("R8", 0, 0, 1, 8'h60, 1, 8'h61);
    idle("R8");
    // R9 same-cycle lead and trail
    step("R9", 1, 8'h30, 0, 0, 0, 0);
    step("R9", 1, 8'h30, 1, 8'h30, 1, 8'h30);
    step("R9", 0, 0, 1, 8'h30, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 8'h30);
    // R6 full tracker
    for (int i = 0; i < DEPTH; i++) step("R6", 1, 8'hA0 + i, 0, 0, 0, 0);
    step("R6", 1, 8'hB0, 0, 0, 1, 8'hB0);
    step("R6", 0, 0, 0, 0, 1, 8'hB0);
    step("R6", 1, 8'hA1, 0, 0, 1, 8'hA2);
    // R10 release one, reuse
    step("R10", 0, 0, 1, 8'hA0, 0, 0);
    step("R10", 1, 8'hB0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 1, 8'hB0);
    step("R10", 1, 8'hC0, 0, 0, 0, 0);
    // R7 saturation on an existing entry
    for (int i = 1; i < MAXC; i++) step("R7", 1, 8'hA3, 0, 0, 0, 0);
    step("R7", 1, 8'hA3, 0, 0, 0, 0);
    for (int i = 0; i < MAXC - 1; i++) step("R7", 0, 0, 1, 8'hA3, 1, 8'hA3);
    step("R7", 0, 0, 0, 0, 1, 8'hA3);
    step("R7", 0, 0, 1, 8'hA3, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 8'hA3);
    idle("R5");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule